// File: doc/BRIEF.md
# Two-Processor Scanline Timer and Display Status

This block produces the line timing of a two-screen handheld display and gives each of two processors its own view of the display status. An in-line cycle counter walks every scanline through a drawing period and then a horizontal-blank period, and a line counter steps once per scanline to count out the frame. From these two counters the block derives a vertical-blank flag, a horizontal-blank flag and a per-processor line-compare match flag. It pulses interrupt requests toward each processor's interrupt controller and pulses a horizontal-blank trigger toward a DMA engine.

The timing core is a two-state machine. `SCAN_DRAW` is the drawing period, where the cycle counter runs from 0 to ACTIVE_CYC-1. The transition `draw_done` fires when the last drawing cycle is reached and moves to `SCAN_HBLANK`, where the counter goes on to ACTIVE_CYC+HBLANK_CYC-1. The transition `line_done` then fires at the end of the line and returns to `SCAN_DRAW`, clearing the counter and stepping the line counter. The line counter wraps to 0 after the last line. Each processor has its own byte-wide register port with four locations, selected by a 2-bit address. Location 0 is status, location 1 is the low byte of the compare value, and locations 2 and 3 are the low and high bytes of the line counter.

Top module: `lcd_line_timer`

## Requirements
- R1: Each scanline lasts ACTIVE_CYC+HBLANK_CYC cycles (default 1536+594=2130). The first ACTIVE_CYC cycles are the drawing state and the rest are the horizontal-blank state.
- R2: The line counter advances by one in the first cycle of each new line. It counts 0..TOTAL_LINES-1 (default 0..262) and then wraps to 0.
- R3: Status bit 0 (vertical blank) is 1 exactly on lines VIS_LINES through TOTAL_LINES-2 (default 192..261), and 0 on the final line.
- R4: Status bit 1 (horizontal blank) is 1 from in-line cycle ACTIVE_CYC+HFLAG_DELAY (default 1606) until the end of the line. It is 0 before that point, including the first HFLAG_DELAY cycles of the blank period.
- R5: A write to location 0 stores bits 3, 4 and 5 as the vertical-blank, horizontal-blank and line-match interrupt enables, and stores bit 7 as bit 8 of the 9-bit compare value. A write to location 1 stores compare bits 7..0. A read of location 0 returns {compare[8], 0, enables[2:0], match, hblank, vblank}, and a read of location 1 returns compare[7:0]. Status bits 0 to 2 are read-only.
- R6: In the first cycle of each line, status bit 2 (match) is reloaded with (line == compare) and then holds for the whole line. In that same cycle a one-cycle line-match request is raised if that processor's match enable is set.
- R7: In the first cycle of line VIS_LINES, a one-cycle vertical-blank request is raised for each processor whose vertical-blank enable is set.
- R8: The horizontal-blank DMA trigger is a one-cycle pulse in the first cycle of the blank period (in-line cycle ACTIVE_CYC). It fires on visible lines 0..VIS_LINES-1 only.
- R9: Location 2 reads line[7:0] and location 3 reads {7'b0, line[8]}. Writes to locations 2 and 3 change nothing.
- R10: The two processors hold separate enables, compare values and match flags. A write on one port never changes what the other port reads or requests.
- R11: A synchronous reset clears both counters, all enables, compare values, match flags and pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr | input | N_CPU | Write strobe, one bit per processor |
| cpu_addr | input | 2*N_CPU | Register location, 2 bits per processor |
| cpu_wdata | input | 8*N_CPU | Write data, a byte per processor |
| cpu_rdata | output | 8*N_CPU | Combinational read data, a byte per processor |
| vblank_irq | output | N_CPU | One-cycle vertical-blank request per processor |
| match_irq | output | N_CPU | One-cycle line-match request per processor |
| hblank_dma | output | 1 | One-cycle horizontal-blank DMA trigger |

## Verification
Read data is combinational from the port address and the registered state, so it is checked in the same cycle the address is applied. Register writes become visible one clock edge after the strobe. All pulses and the match flag are registered on the edge that starts a line or a blank period, so they are due in the first cycle of that line or period. A bench model steps its own cycle and line counters on each rising edge and applies writes after the line-start effects, which mirrors the old-value-at-the-edge rule. Outputs and read data are compared every cycle, half a period after the edge, against values computed from that model.

// File: rtl/lcd_tmg_pkg.sv
package lcd_tmg_pkg;
    localparam int LINE_W = 9;

    typedef enum logic [0:0] {
        SCAN_DRAW   = 1'b0,
        SCAN_HBLANK = 1'b1
    } scan_state_t;

    localparam logic [1:0] SEL_STAT    = 2'd0;
    localparam logic [1:0] SEL_CMP     = 2'd1;
    localparam logic [1:0] SEL_LINE_LO = 2'd2;
    localparam logic [1:0] SEL_LINE_HI = 2'd3;
endpackage

// File: rtl/lcd_scan_fsm.sv
module lcd_scan_fsm
    import lcd_tmg_pkg::*;
#(
    parameter int ACTIVE_CYC  = 1536,
    parameter int HBLANK_CYC  = 594,
    parameter int HFLAG_DELAY = 70,
    parameter int VIS_LINES   = 192,
    parameter int TOTAL_LINES = 263,
    localparam int LINE_CYC   = ACTIVE_CYC + HBLANK_CYC,
    localparam int CNT_W      = $clog2(LINE_CYC)
) (
    input  logic              clk,
    input  logic              rst,
    output scan_state_t       state_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [LINE_W-1:0] line_q,
    output logic [LINE_W-1:0] line_next,
    output logic              line_wrap,
    output logic              vblank_flag,
    output logic              hblank_flag,
    output logic              hdma_q
);
    localparam logic [CNT_W-1:0]  DRAW_LAST = CNT_W'(ACTIVE_CYC - 1);
    localparam logic [CNT_W-1:0]  LINE_LAST = CNT_W'(LINE_CYC - 1);
    localparam logic [CNT_W-1:0]  HFLAG_AT  = CNT_W'(ACTIVE_CYC + HFLAG_DELAY);
    localparam logic [LINE_W-1:0] VIS_L     = LINE_W'(VIS_LINES);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);
    localparam logic [LINE_W-1:0] VB_LAST   = LINE_W'(TOTAL_LINES - 2);

    scan_state_t      state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             draw_done;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_DRAW;
            cnt_q   <= '0;
            line_q  <= '0;
            hdma_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hdma_q  <= draw_done && (line_q < VIS_L);
            if (line_wrap) begin
                line_q <= line_next;
            end
        end
    end

    // next state and transitions
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q + 1'b1;
        draw_done = 1'b0;
        line_wrap = 1'b0;
        unique case (state_q)
            SCAN_DRAW: begin
                if (cnt_q == DRAW_LAST) begin
                    draw_done = 1'b1;
                    state_d   = SCAN_HBLANK;
                end
            end
            SCAN_HBLANK: begin
                if (cnt_q == LINE_LAST) begin
                    line_wrap = 1'b1;
                    state_d   = SCAN_DRAW;
                    cnt_d     = '0;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        line_next   = (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
        vblank_flag = (line_q >= VIS_L) && (line_q <= VB_LAST);
        hblank_flag = (state_q == SCAN_HBLANK) && (cnt_q >= HFLAG_AT);
    end
endmodule

// File: rtl/lcd_cpu_status.sv
module lcd_cpu_status
    import lcd_tmg_pkg::*;
#(
    parameter int VIS_LINES = 192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [LINE_W-1:0] line_q,
    input  logic [LINE_W-1:0] line_next,
    input  logic              line_wrap,
    input  logic              vblank_flag,
    input  logic              hblank_flag,
    output logic              match_q,
    output logic              vb_irq_q,
    output logic              mt_irq_q
);
    localparam logic [LINE_W-1:0] VIS_L = LINE_W'(VIS_LINES);

    logic [2:0]        en_q;
    logic [LINE_W-1:0] cmp_q;
    logic              hit;

    assign hit = (line_next == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            cmp_q    <= '0;
            match_q  <= 1'b0;
            vb_irq_q <= 1'b0;
            mt_irq_q <= 1'b0;
        end else begin
            vb_irq_q <= 1'b0;
            mt_irq_q <= 1'b0;
            if (line_wrap) begin
                match_q  <= hit;
                mt_irq_q <= hit && en_q[2];
                vb_irq_q <= (line_next == VIS_L) && en_q[0];
            end
            if (wr) begin
                unique case (addr)
                    SEL_STAT: begin
                        en_q     <= wdata[5:3];
                        cmp_q[8] <= wdata[7];
                    end
                    SEL_CMP:     cmp_q[7:0] <= wdata;
                    SEL_LINE_LO: ;
                    SEL_LINE_HI: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr)
            SEL_STAT:    rdata = {cmp_q[8], 1'b0, en_q, match_q, hblank_flag, vblank_flag};
            SEL_CMP:     rdata = cmp_q[7:0];
            SEL_LINE_LO: rdata = line_q[7:0];
            SEL_LINE_HI: rdata = {7'b0, line_q[8]};
        endcase
    end
endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
    import lcd_tmg_pkg::*;
#(
    parameter int N_CPU       = 2,
    parameter int ACTIVE_CYC  = 1536,
    parameter int HBLANK_CYC  = 594,
    parameter int HFLAG_DELAY = 70,
    parameter int VIS_LINES   = 192,
    parameter int TOTAL_LINES = 263,
    localparam int CNT_W      = $clog2(ACTIVE_CYC + HBLANK_CYC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_CPU-1:0]   cpu_wr,
    input  logic [2*N_CPU-1:0] cpu_addr,
    input  logic [8*N_CPU-1:0] cpu_wdata,
    output logic [8*N_CPU-1:0] cpu_rdata,
    output logic [N_CPU-1:0]   vblank_irq,
    output logic [N_CPU-1:0]   match_irq,
    output logic               hblank_dma
);
    scan_state_t       state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] line_next;
    logic              line_wrap;
    logic              vblank_flag;
    logic              hblank_flag;
    logic [N_CPU-1:0]  match_flag;

    lcd_scan_fsm #(
        .ACTIVE_CYC (ACTIVE_CYC),
        .HBLANK_CYC (HBLANK_CYC),
        .HFLAG_DELAY(HFLAG_DELAY),
        .VIS_LINES  (VIS_LINES),
        .TOTAL_LINES(TOTAL_LINES)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .state_q    (state_q),
        .cnt_q      (cnt_q),
        .line_q     (line_q),
        .line_next  (line_next),
        .line_wrap  (line_wrap),
        .vblank_flag(vblank_flag),
        .hblank_flag(hblank_flag),
        .hdma_q     (hblank_dma)
    );

    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        lcd_cpu_status #(
            .VIS_LINES(VIS_LINES)
        ) u_stat (
            .clk        (clk),
            .rst        (rst),
            .wr         (cpu_wr[i]),
            .addr       (cpu_addr[2*i +: 2]),
            .wdata      (cpu_wdata[8*i +: 8]),
            .rdata      (cpu_rdata[8*i +: 8]),
            .line_q     (line_q),
            .line_next  (line_next),
            .line_wrap  (line_wrap),
            .vblank_flag(vblank_flag),
            .hblank_flag(hblank_flag),
            .match_q    (match_flag[i]),
            .vb_irq_q   (vblank_irq[i]),
            .mt_irq_q   (match_irq[i])
        );
    end
endmodule

// File: rtl/lcd_line_timer_chk.sv
module lcd_line_timer_chk
    import lcd_tmg_pkg::*;
#(
    parameter int N_CPU       = 2,
    parameter int ACTIVE_CYC  = 1536,
    parameter int HBLANK_CYC  = 594,
    parameter int VIS_LINES   = 192,
    parameter int TOTAL_LINES = 263,
    localparam int CNT_W      = $clog2(ACTIVE_CYC + HBLANK_CYC)
) (
    input logic              clk,
    input logic              rst,
    input scan_state_t       state_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [LINE_W-1:0] line_q,
    input logic [N_CPU-1:0]  match_flag,
    input logic [N_CPU-1:0]  vblank_irq,
    input logic [N_CPU-1:0]  match_irq,
    input logic              hblank_dma
);
    localparam logic [CNT_W-1:0]  DRAW_N    = CNT_W'(ACTIVE_CYC);
    localparam logic [CNT_W-1:0]  LINE_LAST = CNT_W'(ACTIVE_CYC + HBLANK_CYC - 1);
    localparam logic [LINE_W-1:0] VIS_L     = LINE_W'(VIS_LINES);
    localparam logic [LINE_W-1:0] TOT_L     = LINE_W'(TOTAL_LINES);

    // R1
    draw_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SCAN_DRAW) |-> (cnt_q < DRAW_N));
    // R1
    line_len_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LINE_LAST) |=> (cnt_q == '0 && state_q == SCAN_DRAW));
    // R2
    line_range_chk: assert property (@(posedge clk) disable iff (rst)
        line_q < TOT_L);
    // R2
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> $stable(line_q));
    // R8
    dma_visible_chk: assert property (@(posedge clk) disable iff (rst)
        hblank_dma |-> (line_q < VIS_L && cnt_q == DRAW_N));
    // R8
    dma_single_chk: assert property (@(posedge clk) disable iff (rst)
        hblank_dma |=> !hblank_dma);
    // R7
    vb_irq_line_chk: assert property (@(posedge clk) disable iff (rst)
        (|vblank_irq) |-> (line_q == VIS_L && cnt_q == '0));
    // R6
    match_irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (match_irq & ~match_flag) == '0);
    // R6
    match_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> $stable(match_flag));
endmodule

bind lcd_line_timer lcd_line_timer_chk #(
    .N_CPU      (N_CPU),
    .ACTIVE_CYC (ACTIVE_CYC),
    .HBLANK_CYC (HBLANK_CYC),
    .VIS_LINES  (VIS_LINES),
    .TOTAL_LINES(TOTAL_LINES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state_q   (state_q),
    .cnt_q     (cnt_q),
    .line_q    (line_q),
    .match_flag(match_flag),
    .vblank_irq(vblank_irq),
    .match_irq (match_irq),
    .hblank_dma(hblank_dma)
);

// File: tb/tb_lcd_line_timer.sv
module tb_lcd_line_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NC   = 2;
    localparam int ACT  = 48;
    localparam int HB   = 30;
    localparam int DLY  = 7;
    localparam int VIS  = 12;
    localparam int TOT  = 16;
    localparam int LINE = ACT + HB;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NC-1:0]   cpu_wr = '0;
    logic [2*NC-1:0] cpu_addr = '0;
    logic [8*NC-1:0] cpu_wdata = '0;
    logic [8*NC-1:0] cpu_rdata;
    logic [NC-1:0]   vblank_irq;
    logic [NC-1:0]   match_irq;
    logic            hblank_dma;

    int n_chk = 0;
    int n_fail = 0;

    // bench model state
    int       m_cnt = 0;
    int       m_line = 0;
    bit [2:0] m_en [NC];
    bit [8:0] m_cmp [NC];
    bit       m_match [NC];
    bit       e_vb [NC];
    bit       e_mi [NC];
    bit       e_dma = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_line_timer #(
        .N_CPU(NC), .ACTIVE_CYC(ACT), .HBLANK_CYC(HB), .HFLAG_DELAY(DLY),
        .VIS_LINES(VIS), .TOTAL_LINES(TOT)
    ) dut (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vblank_irq(vblank_irq),
        .match_irq(match_irq), .hblank_dma(hblank_dma)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_line = 0; e_dma = 0;
            for (int i = 0; i < NC; i++) begin
                m_en[i] = 0; m_cmp[i] = 0; m_match[i] = 0; e_vb[i] = 0; e_mi[i] = 0;
            end
        end else begin
            e_dma = 0;
            for (int i = 0; i < NC; i++) begin e_vb[i] = 0; e_mi[i] = 0; end
            if (m_cnt == LINE - 1) begin
                m_cnt = 0;
                m_line = (m_line == TOT - 1) ? 0 : m_line + 1;
                for (int i = 0; i < NC; i++) begin
                    m_match[i] = (m_line == int'(m_cmp[i]));
                    e_mi[i] = m_match[i] && m_en[i][2];
                    e_vb[i] = (m_line == VIS) && m_en[i][0];
                end
            end else begin
                m_cnt = m_cnt + 1;
                e_dma = (m_cnt == ACT) && (m_line < VIS);
            end
            for (int i = 0; i < NC; i++) begin
                if (cpu_wr[i]) begin
                    case (cpu_addr[2*i +: 2])
                        2'd0: begin m_en[i] = cpu_wdata[8*i+3 +: 3]; m_cmp[i][8] = cpu_wdata[8*i+7]; end
                        2'd1: m_cmp[i][7:0] = cpu_wdata[8*i +: 8];
                        default: ;
                    endcase
                end
            end
        end
    end

    function automatic logic [7:0] exp_read(input int i, input logic [1:0] a);
        logic vf, hf;
        vf = (m_line >= VIS) && (m_line <= TOT - 2);
        hf = (m_cnt >= ACT + DLY);
        case (a)
            2'd0: exp_read = {m_cmp[i][8], 1'b0, m_en[i], m_match[i], hf, vf};
            2'd1: exp_read = m_cmp[i][7:0];
            2'd2: exp_read = m_line[7:0];
            default: exp_read = {7'b0, m_line[8]};
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (line %0d cyc %0d)", tag, act, exp, m_line, m_cnt);
        end
    endtask

    task automatic check_all();
        string tag;
        for (int i = 0; i < NC; i++) begin
            logic [1:0] a;
            a = cpu_addr[2*i +: 2];
            if (rst) tag = "R11 reset";
            else if (a == 2'd0) tag = "R3 R4 R5 R6 status";
            else if (a == 2'd1) tag = "R5 compare";
            else tag = "R2 R9 line";
            if (i == 1) tag = {"R10 cpu1 ", tag};
            chk(tag, cpu_rdata[8*i +: 8], exp_read(i, a));
            chk(i == 1 ? "R10 R7 vblank irq cpu1" : "R7 vblank irq", vblank_irq[i], e_vb[i]);
            chk(i == 1 ? "R10 R6 match irq cpu1" : "R6 match irq", match_irq[i], e_mi[i]);
        end
        chk("R1 R8 hblank dma", hblank_dma, e_dma);
    endtask

    // one cycle: check after the edge, then drive next inputs
    task automatic step(input logic [NC-1:0] wr, input logic [2*NC-1:0] ad, input logic [8*NC-1:0] wd);
        @(negedge clk);
        #1;
        check_all();
        cpu_wr = wr; cpu_addr = ad; cpu_wdata = wd;
    endtask

    task automatic run_random(input int cycles, input bit allow_wr);
        for (int k = 0; k < cycles; k++) begin
            logic [NC-1:0]   wr;
            logic [2*NC-1:0] ad;
            logic [8*NC-1:0] wd;
            ad = 2*NC'($urandom);
            wr = '0;
            wd = '0;
            for (int i = 0; i < NC; i++) begin
                if (allow_wr && ($urandom_range(0, 63) == 0)) begin
                    wr[i] = 1'b1;
                    if (ad[2*i +: 2] == 2'd1) wd[8*i +: 8] = 8'($urandom_range(0, TOT - 1));
                    else if (ad[2*i +: 2] == 2'd0) wd[8*i +: 8] = {($urandom_range(0, 7) == 0), 7'($urandom)};
                    else wd[8*i +: 8] = 8'($urandom);
                end
            end
            step(wr, ad, wd);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R11: reset state observed on several locations
        step('0, 4'b1000, '0);
        step('0, 4'b0100, '0);
        step('0, 4'b0001, '0);
        rst = 1'b0;
        // directed: cpu0 enables vblank+match, compare = VIS; cpu1 match only, compare 3
        step(2'b11, 4'b0000, {8'h20, 8'h28});
        step(2'b11, 4'b0101, {8'd3, 8'(VIS)});
        // R9: writes to line locations are ignored
        step(2'b11, 4'b1110, 16'hFFFF);
        step('0, 4'b1110, '0);
        run_random(2 * TOT * LINE, 1'b0);
        // compare beyond frame length never matches
        step(2'b01, 4'b0000, {8'h00, 8'hA8});
        step(2'b01, 4'b0001, {8'h00, 8'd5});
        run_random(TOT * LINE, 1'b0);
        run_random(6 * TOT * LINE, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule